// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block takes one interrupt routing request and turns it into a short stream of per-processor delivery messages. A request carries the source pin number, an 8-bit destination, an addressing-mode bit (physical or logical), a 3-bit delivery mode and the vector. Up to eight processors each present a present flag, a physical identifier and a logical identifier. From these the block forms a target set. It then emits one message per clock, each naming a target index and carrying the vector, and marks the final message. A request that reaches nobody, or that asks for a delivery mode the block does not handle, is dropped with a one-cycle drop indication.

The controller is a three-state machine. `ST_IDLE` waits for a request and accepts it while `req_ready` is high. From `ST_IDLE` it takes one of three transitions:
- `T_TO_EMIT` when the target set is non-empty and the mode is supported.
- `T_TO_DROP` when the target set is empty or the mode is unsupported.
- `T_STAY` when no request arrives.

`ST_EMIT` sends the lowest pending target each cycle. It takes `T_EMIT_NEXT` while more than one target remains and `T_EMIT_DONE` back to idle with the last one. `ST_DROP` lasts one cycle and returns to idle through `T_DROP_DONE`.

For lowest-priority delivery the block keeps a rotating pointer. It chooses the first candidate at or above the pointer, wrapping around if none is found, and then moves the pointer to one past the chosen processor.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset `req_ready` is 1, `msg_valid` and `drop_valid` are 0, and the round-robin pointer is 0.
- R2: In physical mode (`req_logical`=0), destination 8'hFF selects every processor whose present flag is set, whatever its physical identifier.
- R3: In physical mode with any other destination, only the lowest-indexed present processor whose physical identifier equals the destination is selected.
- R4: In logical mode (`req_logical`=1), a processor is selected when it is present and its logical identifier ANDed with the destination is non-zero. A destination of 0 therefore selects nobody.
- R5: When the final target set is empty, the block emits no message and raises `drop_valid` for one cycle with `drop_unsupported`=0. This check takes precedence over the mode check.
- R6: Fixed mode (`req_dmode`=3'b000) emits one message per cycle for each target, in ascending index order. Every message carries the request's vector, and `msg_last` is 1 only on the final message.
- R7: Lowest-priority mode (`req_dmode`=3'b001) emits exactly one message, with `msg_last`=1. The target is the first selected processor at or above the pointer, wrapping to the lowest selected one if needed. The pointer then becomes the chosen index plus one, modulo 8.
- R8: A request from pin 0 with a non-empty selection goes only to processor 0 in both supported modes. If processor 0 is absent, the set is empty. Such requests leave the pointer unchanged.
- R9: Any delivery mode other than 3'b000 and 3'b001 with a non-empty target set emits no message and raises `drop_valid` for one cycle with `drop_unsupported`=1.
- R10: The first message or drop appears in the cycle after acceptance. `req_ready` is 0 from then until the cycle after the last message or drop, and a request presented during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_pin | input | PIN_W | Source pin number |
| req_dest | input | DEST_W | Destination field |
| req_logical | input | 1 | 0 = physical, 1 = logical addressing |
| req_dmode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority |
| req_vector | input | VEC_W | Vector to deliver |
| cpu_present | input | NCPU | Per-processor present flag |
| cpu_phys_id | input | NCPU*DEST_W | Physical identifiers; processor i in bits [i*DEST_W +: DEST_W] |
| cpu_logical_id | input | NCPU*DEST_W | Logical identifiers, same packing |
| msg_valid | output | 1 | Delivery message valid |
| msg_target | output | IDX_W | Target processor index |
| msg_vector | output | VEC_W | Vector of the message |
| msg_last | output | 1 | Final message of the request |
| drop_valid | output | 1 | Request dropped with no delivery |
| drop_unsupported | output | 1 | Drop caused by an unsupported mode |

## Verification
The bench goes after the physical-match case in which two present processors share an identifier. A resolver that ORs the matches instead of stopping at the first one would deliver twice. It sets up a physical broadcast in which one processor is absent, which a design that ignores the present flags would still address. It also checks that a logical destination of zero drops the request.

For round-robin arbitration it chains several requests, including a wrap past index 7, and inserts pin-0 requests between them. A pointer that advanced on a pin-0 request, or one that failed to wrap, would choose the wrong processor on a later request. The bench also covers unsupported modes with both empty and non-empty sets, so that a swapped precedence would show up in `drop_unsupported`. Finally, it presents a request while the block is busy; a design that accepted it would emit extra messages.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam logic [2:0] DM_FIXED  = 3'b000;
    localparam logic [2:0] DM_LOWEST = 3'b001;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_DROP = 2'd2
    } rsv_state_e;

endpackage

// File: rtl/irqd_dest_match.sv
module irqd_dest_match #(
    parameter int NCPU   = 8,
    parameter int DEST_W = 8
) (
    input  logic [DEST_W-1:0]      dest,
    input  logic                   logical,
    input  logic [NCPU-1:0]        present,
    input  logic [NCPU*DEST_W-1:0] phys_ids,
    input  logic [NCPU*DEST_W-1:0] log_ids,
    output logic [NCPU-1:0]        mask
);

    logic [NCPU-1:0] phys_hit;
    logic [NCPU-1:0] log_hit;
    logic [NCPU-1:0] phys_first;

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        assign phys_hit[i] = present[i] && (phys_ids[i*DEST_W +: DEST_W] == dest);
        assign log_hit[i]  = present[i] && |(log_ids[i*DEST_W +: DEST_W] & dest);
    end

    // isolate the lowest-indexed physical match
    assign phys_first = phys_hit & (~phys_hit + NCPU'(1));

    always_comb begin
        if (logical) begin
            mask = log_hit;
        end else if (dest == {DEST_W{1'b1}}) begin
            mask = present;
        end else begin
            mask = phys_first;
        end
    end

endmodule

// File: rtl/irqd_rr_pick.sv
module irqd_rr_pick #(
    parameter int NCPU  = 8,
    parameter int IDX_W = 3
) (
    input  logic [NCPU-1:0]  cand,
    input  logic [IDX_W-1:0] ptr,
    output logic [NCPU-1:0]  pick_oh,
    output logic [IDX_W-1:0] pick_idx
);

    logic [NCPU-1:0] at_or_above;
    logic [NCPU-1:0] upper;
    logic [NCPU-1:0] pool;

    for (genvar i = 0; i < NCPU; i++) begin : g_win
        assign at_or_above[i] = (IDX_W'(i) >= ptr);
    end

    assign upper   = cand & at_or_above;
    assign pool    = (|upper) ? upper : cand;
    assign pick_oh = pool & (~pool + NCPU'(1));

    always_comb begin
        pick_idx = '0;
        for (int i = NCPU - 1; i >= 0; i--) begin
            if (pool[i]) pick_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
    import irqd_pkg::*;
#(
    parameter int NCPU   = 8,
    parameter int DEST_W = 8,
    parameter int VEC_W  = 8,
    parameter int PIN_W  = 5,
    localparam int IDX_W = $clog2(NCPU)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [PIN_W-1:0]       req_pin,
    input  logic [DEST_W-1:0]      req_dest,
    input  logic                   req_logical,
    input  logic [2:0]             req_dmode,
    input  logic [VEC_W-1:0]       req_vector,
    input  logic [NCPU-1:0]        cpu_present,
    input  logic [NCPU*DEST_W-1:0] cpu_phys_id,
    input  logic [NCPU*DEST_W-1:0] cpu_logical_id,
    output logic                   msg_valid,
    output logic [IDX_W-1:0]       msg_target,
    output logic [VEC_W-1:0]       msg_vector,
    output logic                   msg_last,
    output logic                   drop_valid,
    output logic                   drop_unsupported
);

    rsv_state_e      state_q, state_d;
    logic [NCPU-1:0] pend_q, pend_d;
    logic [VEC_W-1:0] vec_q, vec_d;
    logic            unsup_q, unsup_d;
    logic [IDX_W-1:0] rr_q, rr_d;

    logic [NCPU-1:0] sel_mask;
    logic [NCPU-1:0] pick_oh;
    logic [IDX_W-1:0] pick_idx;
    logic [NCPU-1:0] final_set;
    logic            take;
    logic            from_pin0;
    logic            mode_ok;
    logic [NCPU-1:0] pend_rest;
    logic [IDX_W-1:0] head_idx;

    irqd_dest_match #(.NCPU(NCPU), .DEST_W(DEST_W)) u_match (
        .dest     (req_dest),
        .logical  (req_logical),
        .present  (cpu_present),
        .phys_ids (cpu_phys_id),
        .log_ids  (cpu_logical_id),
        .mask     (sel_mask)
    );

    irqd_rr_pick #(.NCPU(NCPU), .IDX_W(IDX_W)) u_pick (
        .cand     (sel_mask),
        .ptr      (rr_q),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx)
    );

    assign take      = req_valid && (state_q == ST_IDLE);
    assign from_pin0 = (req_pin == '0);
    assign mode_ok   = (req_dmode == DM_FIXED) || (req_dmode == DM_LOWEST);

    always_comb begin
        if (from_pin0) begin
            final_set = (|sel_mask && cpu_present[0]) ? NCPU'(1) : '0;
        end else if (req_dmode == DM_LOWEST) begin
            final_set = pick_oh;
        end else begin
            final_set = sel_mask;
        end
    end

    assign pend_rest = pend_q & (pend_q - NCPU'(1));

    always_comb begin
        head_idx = '0;
        for (int i = NCPU - 1; i >= 0; i--) begin
            if (pend_q[i]) head_idx = IDX_W'(i);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        vec_d   = vec_q;
        unsup_d = unsup_q;
        rr_d    = rr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    vec_d = req_vector;
                    if (final_set == '0) begin
                        state_d = ST_DROP;      // T_TO_DROP (empty)
                        unsup_d = 1'b0;
                    end else if (!mode_ok) begin
                        state_d = ST_DROP;      // T_TO_DROP (mode)
                        unsup_d = 1'b1;
                    end else begin
                        state_d = ST_EMIT;      // T_TO_EMIT
                        pend_d  = final_set;
                        unsup_d = 1'b0;
                        if (req_dmode == DM_LOWEST && !from_pin0) begin
                            rr_d = (pick_idx == IDX_W'(NCPU - 1)) ? '0 : pick_idx + IDX_W'(1);
                        end
                    end
                end
            end
            ST_EMIT: begin
                pend_d = pend_rest;
                if (pend_rest == '0) state_d = ST_IDLE;   // T_EMIT_DONE
            end
            ST_DROP: begin
                state_d = ST_IDLE;                         // T_DROP_DONE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            vec_q   <= '0;
            unsup_q <= 1'b0;
            rr_q    <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            vec_q   <= vec_d;
            unsup_q <= unsup_d;
            rr_q    <= rr_d;
        end
    end

    // outputs
    always_comb begin
        req_ready        = (state_q == ST_IDLE);
        msg_valid        = (state_q == ST_EMIT);
        msg_target       = head_idx;
        msg_vector       = vec_q;
        msg_last         = (state_q == ST_EMIT) && (pend_rest == '0);
        drop_valid       = (state_q == ST_DROP);
        drop_unsupported = (state_q == ST_DROP) && unsup_q;
    end

    // R3: physical non-broadcast selection never holds more than one processor
    a_r3_phys_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_logical && req_dest != {DEST_W{1'b1}}) |-> $onehot0(sel_mask));

    // R7: the round-robin choice is one processor taken from the candidates
    a_r7_pick_member: assert property (@(posedge clk) disable iff (!rst_n)
        (|sel_mask) |-> ($onehot(pick_oh) && |(pick_oh & sel_mask)));

    // R6: messages and drops never coincide
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_valid && drop_valid));

    // R6: a non-final message is followed by another with a higher index
    a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_last) |=> (msg_valid && msg_target > $past(msg_target)));

    // R6: vector held across one request's messages
    a_r6_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_last) |=> (msg_vector == $past(msg_vector)));

    // R10: acceptance makes the block busy
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: after the final message or drop the block is ready again
    a_r10_return: assert property (@(posedge clk) disable iff (!rst_n)
        ((msg_valid && msg_last) || drop_valid) |=> req_ready);

endmodule

// File: tb/irq_dest_resolver_tb.sv
module irq_dest_resolver_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 8;
    localparam int DW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [4:0]      req_pin = '0;
    logic [7:0]      req_dest = '0;
    logic            req_logical = 1'b0;
    logic [2:0]      req_dmode = '0;
    logic [7:0]      req_vector = '0;
    logic [NCPU-1:0] cpu_present;
    logic [NCPU*DW-1:0] cpu_phys_id;
    logic [NCPU*DW-1:0] cpu_logical_id;
    logic            msg_valid;
    logic [2:0]      msg_target;
    logic [7:0]      msg_vector;
    logic            msg_last;
    logic            drop_valid;
    logic            drop_unsupported;

    int n_tests = 0;
    int n_fail  = 0;
    int rr_ptr  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dest_resolver u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_pin(req_pin), .req_dest(req_dest), .req_logical(req_logical),
        .req_dmode(req_dmode), .req_vector(req_vector),
        .cpu_present(cpu_present), .cpu_phys_id(cpu_phys_id),
        .cpu_logical_id(cpu_logical_id),
        .msg_valid(msg_valid), .msg_target(msg_target), .msg_vector(msg_vector),
        .msg_last(msg_last), .drop_valid(drop_valid),
        .drop_unsupported(drop_unsupported)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural model of the selection rules
    function automatic int sel_bit(int i, int dest, bit logical);
        int p;
        int l;
        p = int'(cpu_phys_id[i*DW +: DW]);
        l = int'(cpu_logical_id[i*DW +: DW]);
        if (!cpu_present[i]) return 0;
        if (logical) return ((l & dest) != 0) ? 1 : 0;
        if (dest == 255) return 1;
        return (p == dest) ? 1 : 0;
    endfunction

    task automatic run_req(input int pin, input int dest, input bit logical,
                           input int dmode, input int vec, input bit poke_busy,
                           input string tag);
        int sel[$];
        int tgt[$];
        bit drop_exp;
        bit unsup_exp;
        for (int i = 0; i < NCPU; i++) begin
            if (sel_bit(i, dest, logical) != 0) begin
                sel.push_back(i);
                if (!logical && dest != 255) break;   // first physical hit only
            end
        end
        drop_exp = 0;
        unsup_exp = 0;
        if (pin == 0) begin
            if (sel.size() > 0 && cpu_present[0]) tgt.push_back(0);
        end else if (dmode == 1) begin
            if (sel.size() > 0) begin
                int choice;
                choice = -1;
                foreach (sel[k]) if (choice < 0 && sel[k] >= rr_ptr) choice = sel[k];
                if (choice < 0) choice = sel[0];
                tgt.push_back(choice);
            end
        end else begin
            tgt = sel;
        end
        if (tgt.size() == 0) drop_exp = 1;
        else if (dmode != 0 && dmode != 1) begin drop_exp = 1; unsup_exp = 1; end
        if (!drop_exp && dmode == 1 && pin != 0) rr_ptr = (tgt[0] + 1) % NCPU;

        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R10 ready before request"}, req_ready, 1);
        req_pin = 5'(pin); req_dest = 8'(dest); req_logical = logical;
        req_dmode = 3'(dmode); req_vector = 8'(vec); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (drop_exp) begin
            chk(drop_valid == 1'b1, {tag, " R5/R9 drop_valid"}, drop_valid, 1);
            chk(drop_unsupported == unsup_exp, {tag, " R9 drop_unsupported"},
                drop_unsupported, unsup_exp);
            chk(msg_valid == 1'b0, {tag, " R5 no message"}, msg_valid, 0);
            chk(req_ready == 1'b0, {tag, " R10 busy"}, req_ready, 0);
            @(negedge clk);
        end else begin
            foreach (tgt[k]) begin
                chk(msg_valid == 1'b1, {tag, " R6 msg_valid"}, msg_valid, 1);
                chk(int'(msg_target) == tgt[k], {tag, " R6/R7 msg_target"},
                    msg_target, tgt[k]);
                chk(int'(msg_vector) == vec, {tag, " R6 msg_vector"}, msg_vector, vec);
                chk(msg_last == (k == tgt.size() - 1), {tag, " R6 msg_last"},
                    msg_last, (k == tgt.size() - 1));
                chk(req_ready == 1'b0, {tag, " R10 busy"}, req_ready, 0);
                if (poke_busy && k == 0) begin
                    req_pin = 5'd9; req_dest = 8'hFF; req_logical = 1'b0;
                    req_dmode = 3'd0; req_vector = 8'hEE; req_valid = 1'b1;
                end
                @(negedge clk);
                req_valid = 1'b0;
            end
        end
        chk(req_ready == 1'b1, {tag, " R10 ready after"}, req_ready, 1);
        chk(msg_valid == 1'b0 && drop_valid == 1'b0, {tag, " R10 quiet after"},
            {msg_valid, drop_valid}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cpu_present = 8'b1110_1111;   // processor 4 absent
        for (int i = 0; i < NCPU; i++) cpu_phys_id[i*DW +: DW] = 8'(8'h10 + i);
        cpu_phys_id[5*DW +: DW] = 8'h22;
        cpu_phys_id[6*DW +: DW] = 8'h22;
        cpu_phys_id[4*DW +: DW] = 8'h30;
        cpu_logical_id = {8'h80, 8'h60, 8'h20, 8'hFF, 8'h0C, 8'h04, 8'h02, 8'h01};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready at reset", req_ready, 1);
        chk(msg_valid == 1'b0, "R1 no message at reset", msg_valid, 0);
        chk(drop_valid == 1'b0, "R1 no drop at reset", drop_valid, 0);

        run_req(3, 8'hFF, 0, 0, 8'h41, 0, "R2 broadcast");
        run_req(3, 8'h22, 0, 0, 8'h42, 0, "R3 first match");
        run_req(3, 8'h30, 0, 0, 8'h43, 0, "R3 absent match");
        run_req(3, 8'h24, 1, 0, 8'h44, 0, "R4 logical");
        run_req(3, 8'h00, 1, 0, 8'h45, 0, "R4 logical zero");
        run_req(7, 8'hFF, 1, 1, 8'h50, 0, "R7 rr first");
        run_req(7, 8'hFF, 1, 1, 8'h51, 0, "R7 rr second");
        run_req(7, 8'h84, 1, 1, 8'h52, 0, "R7 rr skip");
        run_req(0, 8'h80, 1, 1, 8'h53, 0, "R8 pin0 lowest");
        run_req(7, 8'h84, 1, 1, 8'h54, 0, "R7 rr after pin0");
        run_req(7, 8'h84, 1, 1, 8'h55, 0, "R7 rr to top");
        run_req(7, 8'h84, 1, 1, 8'h56, 0, "R7 rr wrap");
        run_req(0, 8'hFF, 0, 0, 8'h57, 0, "R8 pin0 fixed");
        run_req(2, 8'hFF, 0, 4, 8'h58, 0, "R9 unsupported");
        run_req(2, 8'h00, 1, 2, 8'h59, 0, "R5 empty beats R9");
        run_req(5, 8'hFF, 0, 0, 8'h5A, 1, "R10 busy ignore");
        cpu_present = 8'b1110_1110;
        run_req(0, 8'hFF, 0, 0, 8'h5B, 0, "R8 pin0 cpu0 absent");
        cpu_present = 8'b1110_1111;
        run_req(1, 8'h10, 0, 1, 8'h5C, 0, "R7 physical lowest");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule